// File: doc/BRIEF.md
# Guaranteed-Percentage Thread Scheduler

This block picks, every clock cycle, which of four hardware thread slots may issue into a single-issue multithreaded pipeline. Each slot carries an active flag and a programmed share in percent. A power controller marks the start of each scheduling interval and gives its length in pipeline cycles. At that moment every slot's remaining-cycle budget is reloaded with its share scaled to the interval length. Within the interval each active slot is granted exactly its budget, provided its instruction window has something to offer. Once no active slot has budget left, the block stops issuing until the next interval start.

Three states are held. IDLE is the state after reset, before any interval has begun; nothing is granted. RUN grants the lowest-numbered eligible slot each cycle. STALL grants nothing. The transitions are as follows. Start-IDLE goes to RUN or STALL when an interval begins. Exhaust goes from RUN to STALL when no active slot will have budget left after the current cycle. Wake goes from STALL to RUN when an active slot is found with leftover budget, for example after a suspended thread resumes. Restart happens in any state: an interval-start pulse reloads every budget and enables grants in that same cycle.

A "cycle needed" output tells the power controller whether the pipeline must be clocked. It is high whenever a grant is made, and also during bubbles where budget remains but every window with budget is empty. It is low during stall.

Top module: `gps_sched`

## Requirements
- R1: From reset until the first interval-start pulse, `sel_valid` and `cycle_needed` are 0.
- R2: In an interval-start cycle, each slot's budget becomes floor(min(pct,100) × `ivl_len` / 100). Grants from that budget may begin in the same cycle.
- R3: Within one interval, each active slot with a ready window receives exactly its budget of grants, given that the budgets of the active slots sum to no more than the interval length.
- R4: When several slots are eligible (active, budget left, window ready), the lowest index is granted.
- R5: An inactive slot is never granted, and its budget is left unchanged.
- R6: A slot whose window is empty (`win_ready` bit 0) is skipped for that cycle and keeps its budget. The next eligible slot is granted instead.
- R7: Once no active slot has budget left, `sel_valid` and `cycle_needed` stay 0 until the next interval start, as long as the active set does not change.
- R8: `cycle_needed` is 1 in every cycle with a grant. It is also 1 in a bubble where an active slot has budget but no ready window.
- R9: In stall, a slot that becomes active with leftover budget is granted starting one cycle after it becomes active.
- R10: An interval-start pulse in the middle of an interval discards all leftover budgets and reloads them from the current shares and length.
- R11: When `sel_valid` is 0, `sel_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ivl_start | input | 1 | Pulse marking the first cycle of a scheduling interval |
| ivl_len | input | LEN_W (7) | Interval length in pipeline cycles, sampled with `ivl_start` |
| slot_active | input | NUM_SLOTS (4) | Per-slot active flag |
| slot_pct | input | NUM_SLOTS×PCT_W (28) | Per-slot share in percent, slot 0 in the low bits; values above 100 are treated as 100 |
| win_ready | input | NUM_SLOTS (4) | Per-slot instruction window non-empty |
| sel_slot | output | IDX_W (2) | Granted slot index |
| sel_valid | output | 1 | A slot is granted this cycle |
| cycle_needed | output | 1 | Pipeline must be clocked this cycle |

## Verification
Two events can coincide with an ordinary grant: a budget reload and a grant in the same cycle, and the exhaustion of the last budget together with the exit to stall. The bench drives interval-start pulses on cycles where the old interval still has budget. It then checks that the grant in that cycle follows the new budgets and that the old leftovers are gone, both in the grant counts that follow and in the slot chosen. It also makes the final grant of an interval land on the same edge that moves the block to stall, and checks that the very next cycle shows no grant and no clock demand.

// File: rtl/gps_pkg.sv
package gps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } gps_state_e;

endpackage

// File: rtl/gps_quota_scale.sv
module gps_quota_scale #(
    parameter int PCT_W      = 7,
    parameter int LEN_W      = 7,
    parameter int FULL_SCALE = 100
) (
    input  logic [PCT_W-1:0] pct,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] quota
);
    localparam int PROD_W = PCT_W + LEN_W;

    logic [PCT_W-1:0]  pct_c;
    logic [PROD_W-1:0] prod;

    // Share is clamped to full scale, then scaled to the interval length.
    always_comb begin
        pct_c = (pct > PCT_W'(FULL_SCALE)) ? PCT_W'(FULL_SCALE) : pct;
        prod  = PROD_W'(pct_c) * PROD_W'(len);
        quota = LEN_W'(prod / PROD_W'(FULL_SCALE));
    end
endmodule

// File: rtl/gps_slot_counter.sv
module gps_slot_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             take,
    output logic [CNT_W-1:0] eff,
    output logic [CNT_W-1:0] nxt,
    output logic [CNT_W-1:0] held
);
    logic [CNT_W-1:0] rem_q;

    always_comb begin
        eff  = load ? load_val : rem_q;
        nxt  = eff - {{(CNT_W-1){1'b0}}, take};
        held = rem_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= nxt;
    end
endmodule

// File: rtl/gps_pick.sv
module gps_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);
    // Lowest index wins: scan from the top so the last write is the lowest.
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/gps_sched.sv
module gps_sched #(
    parameter  int NUM_SLOTS  = 4,
    parameter  int PCT_W      = 7,
    parameter  int LEN_W      = 7,
    parameter  int FULL_SCALE = 100,
    localparam int IDX_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ivl_start,
    input  logic [LEN_W-1:0]           ivl_len,
    input  logic [NUM_SLOTS-1:0]       slot_active,
    input  logic [NUM_SLOTS*PCT_W-1:0] slot_pct,
    input  logic [NUM_SLOTS-1:0]       win_ready,
    output logic [IDX_W-1:0]           sel_slot,
    output logic                       sel_valid,
    output logic                       cycle_needed
);
    import gps_pkg::*;

    gps_state_e state_q, state_d;

    logic [NUM_SLOTS-1:0] pend_now;
    logic [NUM_SLOTS-1:0] pend_after;
    logic [NUM_SLOTS-1:0] pend_held;
    logic [NUM_SLOTS-1:0] cand;
    logic [NUM_SLOTS-1:0] take;
    logic [IDX_W-1:0]     pick_idx;
    logic                 pick_hit;
    logic                 enable;

    // Per-slot budget: scaler feeding a reloadable down-counter.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [LEN_W-1:0] quota;
        logic [LEN_W-1:0] eff;
        logic [LEN_W-1:0] nxt;
        logic [LEN_W-1:0] held;

        gps_quota_scale #(
            .PCT_W      (PCT_W),
            .LEN_W      (LEN_W),
            .FULL_SCALE (FULL_SCALE)
        ) u_scale (
            .pct   (slot_pct[s*PCT_W +: PCT_W]),
            .len   (ivl_len),
            .quota (quota)
        );

        gps_slot_counter #(
            .CNT_W (LEN_W)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ivl_start),
            .load_val (quota),
            .take     (take[s]),
            .eff      (eff),
            .nxt      (nxt),
            .held     (held)
        );

        always_comb begin
            pend_now[s]   = slot_active[s] && (eff  != '0);
            pend_after[s] = slot_active[s] && (nxt  != '0);
            pend_held[s]  = slot_active[s] && (held != '0);
            cand[s]       = pend_now[s] && win_ready[s];
            take[s]       = sel_valid && (sel_slot == IDX_W'(s));
        end
    end

    gps_pick #(
        .N     (NUM_SLOTS),
        .IDX_W (IDX_W)
    ) u_pick (
        .req (cand),
        .idx (pick_idx),
        .hit (pick_hit)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic: start-IDLE, exhaust, wake, restart.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ivl_start) state_d = (|pend_after) ? ST_RUN : ST_STALL;
            end
            ST_RUN: begin
                state_d = (|pend_after) ? ST_RUN : ST_STALL;
            end
            ST_STALL: begin
                if (ivl_start)       state_d = (|pend_after) ? ST_RUN : ST_STALL;
                else if (|pend_held) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        enable = 1'b0;
        unique case (state_q)
            ST_IDLE:  enable = ivl_start;
            ST_RUN:   enable = 1'b1;
            ST_STALL: enable = ivl_start;
            default:  enable = 1'b0;
        endcase
        sel_valid    = enable && pick_hit;
        sel_slot     = sel_valid ? pick_idx : '0;
        cycle_needed = enable && (|pend_now);
    end
endmodule

// File: rtl/gps_sched_chk.sv
module gps_sched_chk #(
    parameter  int NUM_SLOTS = 4,
    parameter  int IDX_W     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ivl_start,
    input logic [NUM_SLOTS-1:0] slot_active,
    input logic [NUM_SLOTS-1:0] win_ready,
    input logic [IDX_W-1:0]     sel_slot,
    input logic                 sel_valid,
    input logic                 cycle_needed
);
    logic       seen_start;
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_start <= 1'b0;
            age        <= '0;
        end else begin
            if (ivl_start) seen_start <= 1'b1;
            if (age != 2'd3) age <= age + 2'd1;
        end
    end

    a_r1_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_start && !ivl_start) |-> (!sel_valid && !cycle_needed));

    a_r5_active_only: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> slot_active[sel_slot]);

    a_r6_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> win_ready[sel_slot]);

    a_r8_need_covers_grant: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> cycle_needed);

    a_r11_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (sel_slot == '0));

    a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && $past(!cycle_needed) && !ivl_start
         && $stable(slot_active) && $past(slot_active, 2) == slot_active)
        |-> !sel_valid);
endmodule

bind gps_sched gps_sched_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ivl_start    (ivl_start),
    .slot_active  (slot_active),
    .win_ready    (win_ready),
    .sel_slot     (sel_slot),
    .sel_valid    (sel_valid),
    .cycle_needed (cycle_needed)
);

// File: tb/gps_sched_tb.sv
module gps_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ivl_start;
    logic [6:0]  ivl_len;
    logic [3:0]  slot_active;
    logic [27:0] slot_pct;
    logic [3:0]  win_ready;
    logic [1:0]  sel_slot;
    logic        sel_valid;
    logic        cycle_needed;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gps_sched u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ivl_start    (ivl_start),
        .ivl_len      (ivl_len),
        .slot_active  (slot_active),
        .slot_pct     (slot_pct),
        .win_ready    (win_ready),
        .sel_slot     (sel_slot),
        .sel_valid    (sel_valid),
        .cycle_needed (cycle_needed)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Row: start, len, active, ready, exp_valid, exp_slot, exp_need.
    // Shares for the table: slot0 10, slot1 15, slot2 5, slot3 50.
    localparam logic [19:0] VEC [0:14] = '{
        {1'b1, 7'd20, 4'b0111, 4'b1111, 1'b1, 2'd0, 1'b1}, // R2 budgets 2,3,1,10
        {1'b0, 7'd20, 4'b0111, 4'b1111, 1'b1, 2'd0, 1'b1}, // R4
        {1'b0, 7'd20, 4'b0111, 4'b1101, 1'b1, 2'd2, 1'b1}, // R6 slot1 empty
        {1'b0, 7'd20, 4'b0111, 4'b1101, 1'b0, 2'd0, 1'b1}, // R8 bubble
        {1'b0, 7'd20, 4'b0111, 4'b1111, 1'b1, 2'd1, 1'b1}, // R6 kept budget
        {1'b0, 7'd20, 4'b0111, 4'b1111, 1'b1, 2'd1, 1'b1},
        {1'b0, 7'd20, 4'b0111, 4'b1111, 1'b1, 2'd1, 1'b1}, // last grant
        {1'b0, 7'd20, 4'b0111, 4'b1111, 1'b0, 2'd0, 1'b0}, // R7 stall
        {1'b0, 7'd20, 4'b1111, 4'b1111, 1'b0, 2'd0, 1'b0}, // R9 wake pending
        {1'b0, 7'd20, 4'b1111, 4'b1111, 1'b1, 2'd3, 1'b1}, // R9 R5 kept budget
        {1'b0, 7'd20, 4'b0111, 4'b1111, 1'b0, 2'd0, 1'b0}, // R5 suspended
        {1'b1, 7'd10, 4'b1111, 4'b1111, 1'b1, 2'd0, 1'b1}, // R10 budgets 1,1,0,5
        {1'b0, 7'd10, 4'b1111, 4'b1111, 1'b1, 2'd1, 1'b1},
        {1'b0, 7'd10, 4'b1111, 4'b1111, 1'b1, 2'd3, 1'b1}, // R2 slot2 floor 0
        {1'b0, 7'd10, 4'b1111, 4'b0111, 1'b0, 2'd0, 1'b1}  // R8 bubble
    };

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt [4];
        int order_bad;
        int idle_need;
        int g;

        rst_n       = 1'b0;
        ivl_start   = 1'b0;
        ivl_len     = 7'd20;
        slot_active = 4'b1111;
        win_ready   = 4'b1111;
        slot_pct    = {7'd50, 7'd5, 7'd15, 7'd10};

        repeat (3) @(negedge clk);
        #1;
        chk("R1 valid in reset", int'(sel_valid), 0);
        chk("R1 need in reset", int'(cycle_needed), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 valid before start", int'(sel_valid), 0);
        chk("R1 need before start", int'(cycle_needed), 0);
        chk("R11 index idle", int'(sel_slot), 0);

        for (int r = 0; r < 15; r++) begin
            @(negedge clk);
            ivl_start   = VEC[r][19];
            ivl_len     = VEC[r][18:12];
            slot_active = VEC[r][11:8];
            win_ready   = VEC[r][7:4];
            #1;
            chk($sformatf("R4/R6 row %0d valid", r), int'(sel_valid), int'(VEC[r][3]));
            chk($sformatf("R4/R11 row %0d slot", r), int'(sel_slot), int'(VEC[r][2:1]));
            chk($sformatf("R7/R8 row %0d need", r), int'(cycle_needed), int'(VEC[r][0]));
        end

        // R3 R4 R5 R7: shares 30,30,30,40, slot3 inactive, 100-cycle interval.
        slot_pct = {7'd40, 7'd30, 7'd30, 7'd30};
        for (int k = 0; k < 4; k++) cnt[k] = 0;
        order_bad = 0;
        idle_need = 0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            ivl_start   = (c == 0);
            ivl_len     = 7'd100;
            slot_active = 4'b0111;
            win_ready   = 4'b1111;
            #1;
            if (sel_valid) cnt[sel_slot]++;
            if (c < 90) begin
                if (!sel_valid || int'(sel_slot) != c / 30) order_bad++;
            end else begin
                if (sel_valid || cycle_needed) idle_need++;
            end
        end
        chk("R3 slot0 grants", cnt[0], 30);
        chk("R3 slot1 grants", cnt[1], 30);
        chk("R3 slot2 grants", cnt[2], 30);
        chk("R5 inactive slot3 grants", cnt[3], 0);
        chk("R4 lowest-first order", order_bad, 0);
        chk("R7 stall after exhaustion", idle_need, 0);

        // R2 clamp: share 120 on slot0 alone, length 8.
        slot_pct = {7'd0, 7'd0, 7'd0, 7'd120};
        g = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            ivl_start   = (c == 0);
            ivl_len     = 7'd8;
            slot_active = 4'b0001;
            #1;
            if (sel_valid) g++;
        end
        chk("R2 clamped share grants", g, 8);

        // R10: restart mid-interval discards leftover budget.
        slot_pct = {7'd0, 7'd0, 7'd0, 7'd50};
        g = 0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            ivl_start = (c == 0);
            ivl_len   = 7'd20;
            #1;
        end
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            ivl_start = (c == 0);
            ivl_len   = 7'd4;
            #1;
            if (sel_valid) g++;
        end
        chk("R10 grants after restart", g, 2);

        @(negedge clk);
        ivl_start = 1'b0;
        finish_run();
    end
endmodule